// File: doc/BRIEF.md
# I2C Target Controller with Software-Paced Clock Stretching

This block is a target-side I2C endpoint. It watches the open-drain SCL and SDA lines, finds START and STOP conditions, matches a fixed 7-bit address and moves bytes between the bus and a small register port. That port has one data register and one read-only status word. The controller acknowledges its own address and every byte it receives. When the master asks to read, the controller shifts out the byte that software wrote, most significant bit first.

Software paces the transfer. When a received byte is waiting, or when the master wants a byte that software has not yet supplied, the controller holds SCL low. It lets SCL go only after software reads or writes the data register. The status word shows which side is waiting. It also marks the first byte that follows the address in a write transfer, so software can tell a command or sub-address byte from payload bytes.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset the status word reads 0, and both `scl_oe` and `sda_oe` are 0 (both lines released).
- R2: A master that sends the address equal to `OWN_ADDR` gets an ACK: SDA is low during the ninth clock. Any other address gets no ACK (SDA stays high).
- R3: In a write transfer, each byte is shifted in MSB first. A data-register read (`reg_sel`=0) returns it in bits 7:0. Every received byte is ACKed on the ninth clock.
- R4: While status bit 0 (receive pending) is set during the acknowledge clock, SCL is held low. A data-register read clears the bit and releases SCL.
- R5: Status bit 2 (first byte) is set together with bit 0 only for the first byte after the address, including after a repeated START. A data-register read clears it. It is never set without bit 0.
- R6: An address with the R/W bit at 1 sets status bit 1 (transmit pending) and holds SCL low. A data-register write clears the bit, releases SCL, and the written byte appears on SDA MSB first.
- R7: After a transmitted byte, a master ACK raises status bit 1 again and stretches again. A master NACK leaves status 0 and releases both SCL and SDA.
- R8: Status bit 2 is never set while status bit 1 is set or during a read transfer.
- R9: A STOP, or a START, clears status bits 0, 1 and 2 and releases SCL. A repeated START begins a new address phase.
- R10: Status bits 31:3 read 0. Reading the status word (`reg_sel`=1) changes no bit.
- R11: `sda_oe` changes only while SCL is low, so the controller never creates a START or STOP itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen on the pad |
| sda_i | input | 1 | SDA line level as seen on the pad |
| scl_oe | output | 1 | 1 pulls SCL low (stretch); 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_sel | input | 1 | 0 selects the data register, 1 the status word |
| reg_rd | input | 1 | One-cycle read strobe for the selected register |
| reg_wr | input | 1 | One-cycle write strobe for the selected register |
| reg_wdata | input | 8 | Byte to transmit, taken on a data-register write |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |

## Verification
The assertions check, on every cycle, these relations among the request flags: a stretch always has a pending request behind it; the first-byte flag lives only inside a receive request and never alongside a transmit request; a data-register read or write drops its request on the next cycle; a bus condition wipes all flags; and SDA is only ever pulled while SCL is low. Other properties need a bus master model and can only be shown by the bench's scenarios. These are: the address decode across all 128 addresses, the bit order of received and sent bytes, the ACK and NACK outcomes, the length of a stretch while software stays idle, and the first-byte flag coming back after a repeated START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_t;

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                 input logic bit_in);
    return {cur[BYTE_W-2:0], bit_in};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] addr_byte,
                                    input logic [6:0] own);
    return addr_byte[BYTE_W-1:1] == own;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic rx_pend,
                                                   input logic tx_pend,
                                                   input logic first_b);
    logic [REG_W-1:0] w;
    w    = '0;
    w[0] = rx_pend;
    w[1] = tx_pend;
    w[2] = first_b;
    return w;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= {STAGES{RST_VAL}};
        else        ff <= {ff[STAGES-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= {STAGES{RST_VAL}};
        else        ff <= din;
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];

endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA edges with SCL high in both samples are bus conditions
  assign start_ev = scl_s && scl_q &&  sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q &&  sda_s;
  assign scl_rise =  scl_s && !scl_q;
  assign scl_fall = !scl_s &&  scl_q;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              rreq,
  input  logic              treq,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              bus_clr,
  output logic              set_rx,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_first,
  output logic              set_tx
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              mack;
  logic              first_pend;

  assign bus_clr  = start_ev | stop_ev;
  assign rx_byte  = shift_in(sh, sda_s);
  assign rx_first = first_pend;
  assign set_rx   = (st == ST_RX) && scl_rise && (cnt == CNT_LAST);
  assign set_tx   = scl_fall &&
                    (((st == ST_ADDR_ACK) && sh[0]) || ((st == ST_TX_ACK) && mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      mack       <= 1'b0;
      first_pend <= 1'b0;
    end else if (bus_clr) begin
      st         <= start_ev ? ST_ADDR : ST_IDLE;
      cnt        <= '0;
      first_pend <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise && cnt < CNT_FULL) begin
            sh  <= shift_in(sh, sda_s);
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            st <= addr_hit(sh, OWN_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (sh[0]) begin
              st <= ST_TX_WAIT;
            end else begin
              st         <= ST_RX;
              cnt        <= '0;
              first_pend <= 1'b1;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && cnt < CNT_FULL) begin
            sh  <= shift_in(sh, sda_s);
            cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) first_pend <= 1'b0;
          end else if (scl_fall && cnt == CNT_FULL) begin
            st <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            st  <= ST_RX;
            cnt <= '0;
          end
        end
        ST_TX_WAIT: begin
          if (tx_load) begin
            sh  <= tx_byte;
            cnt <= '0;
            st  <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              st <= ST_TX_ACK;
            end else begin
              sh  <= {sh[BYTE_W-2:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= !sda_s;
          if (scl_fall) st <= mack ? ST_TX_WAIT : ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == ST_ADDR_ACK) || (st == ST_RX_ACK) ||
                  ((st == ST_TX) && !sh[BYTE_W-1]);
  assign scl_oe = ((st == ST_RX_ACK) && rreq) || ((st == ST_TX_WAIT) && treq);

endmodule

// File: rtl/i2c_tgt_csr.sv
module i2c_tgt_csr
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clr,
  input  logic              set_rx,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_first,
  input  logic              set_tx,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  output logic              rreq,
  output logic              treq,
  output logic              fbr,
  output logic              rd_data,
  output logic              tx_load,
  output logic [REG_W-1:0]  reg_rdata
);

  logic [BYTE_W-1:0] rx_hold;

  assign rd_data = reg_rd && (reg_sel == SEL_DATA);
  assign tx_load = reg_wr && (reg_sel == SEL_DATA) && treq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rreq    <= 1'b0;
      treq    <= 1'b0;
      fbr     <= 1'b0;
      rx_hold <= '0;
    end else if (bus_clr) begin
      rreq <= 1'b0;
      treq <= 1'b0;
      fbr  <= 1'b0;
    end else begin
      if (set_rx) begin
        rreq    <= 1'b1;
        fbr     <= rx_first;
        rx_hold <= rx_byte;
      end else if (rd_data) begin
        rreq <= 1'b0;
        fbr  <= 1'b0;
      end
      if (set_tx)       treq <= 1'b1;
      else if (tx_load) treq <= 1'b0;
    end
  end

  assign reg_rdata = (reg_sel == SEL_STAT) ? pack_status(rreq, treq, fbr)
                                           : {{(REG_W-BYTE_W){1'b0}}, rx_hold};

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);

  logic              scl_s, sda_s;
  logic              start_ev, stop_ev, scl_rise, scl_fall;
  logic              bus_clr, set_rx, set_tx, rx_first;
  logic [BYTE_W-1:0] rx_byte;
  logic              rreq, treq, fbr, rd_data, tx_load;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s)
  );

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
  );

  i2c_tgt_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_tgt_engine #(.OWN_ADDR(OWN_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .rreq(rreq), .treq(treq), .tx_load(tx_load), .tx_byte(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_clr(bus_clr),
    .set_rx(set_rx), .rx_byte(rx_byte), .rx_first(rx_first), .set_tx(set_tx)
  );

  i2c_tgt_csr u_csr (
    .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr),
    .set_rx(set_rx), .rx_byte(rx_byte), .rx_first(rx_first), .set_tx(set_tx),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .rreq(rreq), .treq(treq), .fbr(fbr),
    .rd_data(rd_data), .tx_load(tx_load), .reg_rdata(reg_rdata)
  );

endmodule

// File: rtl/i2c_tgt_stretch_chk.sv
module i2c_tgt_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_oe,
  input logic sda_oe,
  input logic rreq,
  input logic treq,
  input logic fbr,
  input logic start_ev,
  input logic stop_ev,
  input logic rd_data,
  input logic tx_load,
  input logic set_rx
);

  // R4
  stretch_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (rreq || treq));

  // R5
  fbr_within_rreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fbr |-> rreq);

  // R8
  fbr_not_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    treq |-> (!fbr && !rreq));

  // R9
  bus_event_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> (!rreq && !treq && !fbr && !scl_oe));

  // R4
  read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !set_rx) |=> (!rreq && !fbr));

  // R6
  write_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!treq && !scl_oe));

  // R11
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

bind i2c_tgt_stretch i2c_tgt_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .rreq(rreq), .treq(treq), .fbr(fbr), .start_ev(start_ev), .stop_ev(stop_ev),
  .rd_data(rd_data), .tx_load(tx_load), .set_rx(set_rx)
);

// File: tb/i2c_tgt_stretch_tb.sv
`timescale 1ns/1ps
module i2c_tgt_stretch_tb;

  localparam logic [6:0] OWN = 7'h2A;
  localparam int HP = 12;
  localparam int HOLD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl_oe = 1'b0;
  logic        m_sda_oe = 1'b0;
  logic        reg_sel = 1'b1;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe;
  wire         scl_line = !(m_scl_oe || scl_oe);
  wire         sda_line = !(m_sda_oe || sda_oe);

  int n_chk = 0;
  int n_fail = 0;
  int r11_bad = 0;

  always #4 clk = ~clk;

  i2c_tgt_stretch #(.OWN_ADDR(OWN)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // R11 monitor: the target's SDA pull may only move while SCL is low
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && scl_line && prev_scl) r11_bad++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_pulse(output logic s);
    m_scl_oe = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(HP);
    s = sda_line;
    m_scl_oe = 1'b1;
    tick(HP);
  endtask

  task automatic put_bit(input logic b);
    logic d;
    m_sda_oe = !b;
    tick(HP);
    clk_pulse(d);
  endtask

  task automatic get_bit(output logic s);
    m_sda_oe = 1'b0;
    tick(HP);
    clk_pulse(s);
  endtask

  task automatic start_cond;
    m_sda_oe = 1'b0;
    tick(HP);
    m_scl_oe = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(HP);
    m_sda_oe = 1'b1;
    tick(HP);
    m_scl_oe = 1'b1;
    tick(HP);
  endtask

  task automatic stop_cond;
    m_sda_oe = 1'b1;
    tick(HP);
    m_scl_oe = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(HP);
    m_sda_oe = 1'b0;
    tick(HP);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic acked);
    logic s;
    for (int i = 6; i >= 0; i--) put_bit(a[i]);
    put_bit(rw);
    get_bit(s);
    acked = !s;
  endtask

  task automatic read_status(output logic [31:0] v);
    @(negedge clk);
    reg_sel = 1'b1;
    reg_rd  = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_data(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b0;
    reg_rd  = 1'b1;
    #1 v = reg_rdata[7:0];
    @(negedge clk);
    reg_rd  = 1'b0;
    reg_sel = 1'b1;
  endtask

  task automatic write_data(input logic [7:0] b);
    @(negedge clk);
    reg_sel   = 1'b0;
    reg_wr    = 1'b1;
    reg_wdata = b;
    @(negedge clk);
    reg_wr  = 1'b0;
    reg_sel = 1'b1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] st;
    logic [7:0]  rb;
    logic        ack, s;
    logic [7:0]  wr_bytes [5];
    logic [7:0]  rd_bytes [4];
    wr_bytes = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};
    rd_bytes = '{8'h96, 8'h00, 8'hFF, 8'h41};

    tick(5);
    chk("R1 oe in reset", {30'd0, scl_oe, sda_oe}, 32'd0);
    rst_n = 1'b1;
    tick(3);
    read_status(st);
    chk("R1 status after reset", st, 32'd0);
    chk("R1 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

    // R2: sweep every address with a write request
    for (int a = 0; a < 128; a++) begin
      start_cond();
      send_addr(7'(a), 1'b0, ack);
      chk("R2 address ack", {31'd0, ack}, {31'd0, (7'(a) == OWN)});
      stop_cond();
    end
    read_status(st);
    chk("R9 status idle after sweep", st, 32'd0);

    // R3 R4 R5 R10: write transfer with software-paced reads
    start_cond();
    send_addr(OWN, 1'b0, ack);
    chk("R2 own address", {31'd0, ack}, 32'd1);
    for (int k = 0; k < 5; k++) begin
      for (int i = 7; i >= 0; i--) put_bit(wr_bytes[k][i]);
      m_sda_oe = 1'b0;
      tick(HP);
      m_scl_oe = 1'b0;
      tick(HOLD);
      chk("R4 SCL held while byte pending", {31'd0, scl_line}, 32'd0);
      read_status(st);
      chk("R5 status with pending byte", st, (k == 0) ? 32'd5 : 32'd1);
      read_status(st);
      chk("R10 status read has no side effect", st, (k == 0) ? 32'd5 : 32'd1);
      read_data(rb);
      chk("R3 received byte", {24'd0, rb}, {24'd0, wr_bytes[k]});
      read_status(st);
      chk("R5 read clears request and first flag", st, 32'd0);
      clk_pulse(s);
      chk("R3 data ACK", {31'd0, s}, 32'd0);
    end
    stop_cond();

    // R6 R7 R8: read transfer
    start_cond();
    send_addr(OWN, 1'b1, ack);
    chk("R6 own address read ack", {31'd0, ack}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      m_sda_oe = 1'b0;
      m_scl_oe = 1'b0;
      tick(HOLD);
      chk("R6 SCL held for transmit data", {31'd0, scl_line}, 32'd0);
      read_status(st);
      chk("R8 transmit request without first flag", st, 32'd2);
      write_data(rd_bytes[k]);
      rb = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        get_bit(s);
        rb[i] = s;
      end
      chk("R6 transmitted byte MSB first", {24'd0, rb}, {24'd0, rd_bytes[k]});
      put_bit(k == 3);
    end
    m_sda_oe = 1'b0;
    m_scl_oe = 1'b0;
    tick(HOLD);
    chk("R7 NACK leaves SCL released", {31'd0, scl_line}, 32'd1);
    chk("R7 NACK leaves SDA released", {31'd0, sda_line}, 32'd1);
    read_status(st);
    chk("R7 no new transmit request", st, 32'd0);
    m_scl_oe = 1'b1;
    tick(HP);
    stop_cond();

    // R9: STOP while a byte is pending
    start_cond();
    send_addr(OWN, 1'b0, ack);
    for (int i = 7; i >= 1; i--) put_bit(1'b0);
    m_sda_oe = 1'b1;
    tick(HP);
    m_scl_oe = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(HP);
    read_status(st);
    chk("R5 pending first byte before STOP", st, 32'd5);
    m_sda_oe = 1'b0;
    tick(HP);
    read_status(st);
    chk("R9 STOP clears status", st, 32'd0);
    chk("R9 STOP releases SCL", {31'd0, scl_oe}, 32'd0);

    // R9: repeated START while a byte is pending
    start_cond();
    send_addr(OWN, 1'b0, ack);
    for (int i = 7; i >= 1; i--) put_bit(i[0]);
    m_sda_oe = 1'b0;
    tick(HP);
    m_scl_oe = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(HP);
    read_status(st);
    chk("R5 pending first byte before restart", st, 32'd5);
    m_sda_oe = 1'b1;
    tick(HP);
    read_status(st);
    chk("R9 START clears status", st, 32'd0);
    m_scl_oe = 1'b1;
    tick(HP);
    send_addr(OWN, 1'b0, ack);
    chk("R9 address after repeated START", {31'd0, ack}, 32'd1);
    for (int i = 7; i >= 0; i--) put_bit(rd_bytes[3][i]);
    m_sda_oe = 1'b0;
    tick(HP);
    m_scl_oe = 1'b0;
    tick(HOLD);
    read_status(st);
    chk("R5 first flag again after restart", st, 32'd5);
    read_data(rb);
    chk("R3 byte after restart", {24'd0, rb}, {24'd0, rd_bytes[3]});
    clk_pulse(s);
    chk("R3 ACK after restart", {31'd0, s}, 32'd0);
    stop_cond();

    chk("R11 SDA pull moved only with SCL low", r11_bad, 32'd0);
    summary();
    $finish;
  end

endmodule